// File: doc/BRIEF.md
# Chip-Select Clocked Serial Port with Block Transfer

This block is a clock-synchronous serial port with a chip-select input that moves a whole run of bytes between the serial line and a 32-entry byte buffer with no host work per byte. The host fills the buffer, sets the run length, bit order, clock source and chip-select gating, then pulses `start`. Each byte leaves on SO from its buffer entry. The byte received on SI during those same eight bit cells replaces that entry. When the run ends, `busy` clears and `done` pulses. The host then reads the received bytes back from the buffer.

The serial clock is either made inside the block (16 system clocks per bit, idling high) or taken from the SCK pin through a two-flop synchronizer. When chip-select gating is on, a high CS holds SO and SCK in high impedance. A run that has not begun a byte waits while CS is high. If CS rises part way through a byte, the run is abandoned: `aborted` is raised and the count of completed bytes stays visible.

Top module: `csio_autoxfer`

## Requirements
- R1: A run moves exactly `len_m1`+1 bytes (1 to 32), taking the transmit byte for the k-th bit cell group from buffer address k, in address order starting at 0.
- R2: With `lsb_first`=0 each byte is sent and received most significant bit first; with `lsb_first`=1 it is sent and received least significant bit first.
- R3: SI is sampled on each rising SCK edge, and the assembled byte is written to the buffer address whose byte was just sent.
- R4: SO changes only after a falling SCK edge and is stable while SCK is high.
- R5: With `ext_clk`=0 the block drives SCK itself. SCK idles high, and every bit cell opens with a falling edge. Each low phase and each high phase lasts 8 system clocks, so one bit takes 16. SCK runs without a gap from one byte to the next.
- R6: With `ext_clk`=1 `sck_oe` stays 0, and bits advance on the edges of `sck_i` after a two-flop synchronizer.
- R7: With `cs_en`=1, `so_oe` and `sck_oe` follow a low `cs_n` with at least one system clock of delay in each direction. They are 0 while `cs_n` is high. A started run does not begin its first bit until `cs_n` is low.
- R8: With `cs_en`=1, CS rising while a byte is partly shifted ends the run. `busy` clears, `aborted` becomes 1, `done` does not pulse, and `done_cnt` holds the number of bytes fully completed. Those bytes are already stored in the buffer.
- R9: When the last byte completes, `busy` clears, `done` is 1 for exactly one cycle, and `done_cnt` equals the run length.
- R10: `buf_rdata` shows the buffer entry at `buf_addr` in the same cycle. Host writes made while `busy` is 1 are ignored.
- R11: After reset `busy`, `done` and `aborted` are 0, `done_cnt` is 0 and `sck_o` is 1. With `cs_en`=1 and `cs_n` high, both output enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that begins a run while idle |
| len_m1 | input | 5 | Run length minus one |
| lsb_first | input | 1 | 1 selects least significant bit first |
| ext_clk | input | 1 | 1 takes SCK from the pin, 0 generates it |
| cs_en | input | 1 | 1 makes CS gate the port |
| buf_we | input | 1 | Host buffer write strobe |
| buf_addr | input | 5 | Host buffer address |
| buf_wdata | input | 8 | Host buffer write data |
| buf_rdata | output | 8 | Buffer entry at `buf_addr` |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse at normal completion |
| aborted | output | 1 | Last run ended by CS |
| done_cnt | output | 6 | Bytes completed in the current or last run |
| sck_i | input | 1 | SCK pin input |
| sck_o | output | 1 | SCK pin output value |
| sck_oe | output | 1 | SCK pin output enable |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | SO output enable |
| cs_n | input | 1 | Active-low chip select |

## Verification
A wrong bit counter or bit-order select first shows on SO: the wrong value is present at the very next rising SCK, and the bench's slave model compares SO at every one of those edges. A mistimed divider is caught within one bit cell, because the model measures every phase of SCK in clock cycles. A wrong byte index or write-back address only appears when the buffer is read back after the run, so every run ends with a full read-back against the bytes the model shifted in. Chip-select faults show within three clocks on the output enables, and an abort that loses its byte count is read directly from `done_cnt`.

// File: rtl/csio_autoxfer.sv
module csio_autoxfer #(
  parameter int DEPTH = 32,
  parameter int HALF  = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(2*HALF)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] len_m1,
  input  logic          lsb_first,
  input  logic          ext_clk,
  input  logic          cs_en,
  input  logic          buf_we,
  input  logic [AW-1:0] buf_addr,
  input  logic [7:0]    buf_wdata,
  output logic [7:0]    buf_rdata,
  output logic          busy,
  output logic          done,
  output logic          aborted,
  output logic [AW:0]   done_cnt,
  input  logic          sck_i,
  output logic          sck_o,
  output logic          sck_oe,
  input  logic          si,
  output logic          so,
  output logic          so_oe,
  input  logic          cs_n
);
  localparam logic [CW-1:0] HALF_V = CW'(HALF);
  localparam logic [CW-1:0] LAST_V = CW'(2*HALF-1);

  logic [7:0]    mem [DEPTH];
  logic [1:0]    cs_sy;
  logic [2:0]    sck_sy;
  logic [CW-1:0] div;
  logic          busy_q, done_q, abort_q, inbyte, so_q;
  logic [2:0]    bit_q;
  logic [AW-1:0] idx, last;
  logic [AW:0]   cnt_q;
  logic [7:0]    txb, rxb;

  logic cs_low, enabled, run, fall_ev, rise_ev, byte_end, tx_bit;
  logic [7:0] rx_next;

  assign cs_low   = ~cs_sy[1];
  assign enabled  = ~cs_en | cs_low;
  assign run      = busy_q & enabled;
  assign fall_ev  = run & (ext_clk ? (sck_sy[2] & ~sck_sy[1]) : (div == '0));
  assign rise_ev  = run & (ext_clk ? (~sck_sy[2] & sck_sy[1]) : (div == HALF_V));
  assign byte_end = rise_ev & (bit_q == 3'd7);
  assign tx_bit   = lsb_first ? txb[bit_q] : txb[3'd7 - bit_q];
  assign rx_next  = lsb_first ? {si, rxb[7:1]} : {rxb[6:0], si};

  assign buf_rdata = mem[buf_addr];
  assign busy      = busy_q;
  assign done      = done_q;
  assign aborted   = abort_q;
  assign done_cnt  = cnt_q;
  assign so        = so_q;
  assign so_oe     = enabled;
  assign sck_oe    = enabled & ~ext_clk;
  assign sck_o     = ~(run & ~ext_clk & (div < HALF_V));

  always_ff @(posedge clk) begin
    if (!busy_q && buf_we)
      mem[buf_addr] <= buf_wdata;
    else if (byte_end)
      mem[idx] <= rx_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sy   <= 2'b11;
      sck_sy  <= 3'b111;
      div     <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      abort_q <= 1'b0;
      inbyte  <= 1'b0;
      so_q    <= 1'b1;
      bit_q   <= '0;
      idx     <= '0;
      last    <= '0;
      cnt_q   <= '0;
      txb     <= '0;
      rxb     <= '0;
    end else begin
      cs_sy  <= {cs_sy[0], cs_n};
      sck_sy <= {sck_sy[1:0], sck_i};
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q  <= 1'b1;
          abort_q <= 1'b0;
          inbyte  <= 1'b0;
          idx     <= '0;
          last    <= len_m1;
          cnt_q   <= '0;
          bit_q   <= '0;
          div     <= '0;
          txb     <= mem[0];
        end
      end else if (!enabled) begin
        div <= '0;
        if (inbyte) begin
          busy_q  <= 1'b0;
          abort_q <= 1'b1;
        end
      end else begin
        div <= (div == LAST_V) ? '0 : div + 1'b1;
        if (fall_ev) begin
          so_q   <= tx_bit;
          inbyte <= 1'b1;
        end
        if (rise_ev) begin
          rxb   <= rx_next;
          bit_q <= bit_q + 1'b1;
          if (bit_q == 3'd7) begin
            cnt_q  <= cnt_q + 1'b1;
            inbyte <= 1'b0;
            if (idx == last) begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
            end else begin
              idx <= idx + 1'b1;
              txb <= mem[idx + 1'b1];
            end
          end
        end
      end
    end
  end

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy) && !aborted));

  // R8
  abort_nodone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aborted) |-> (!busy && !done));

  // R4
  so_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_oe && $past(sck_oe) && sck_o && $past(sck_o)) |-> $stable(so));

  // R5
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sck_o);

  // R1
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (done_cnt <= {1'b0, last} + 1'b1));
endmodule

// File: tb/csio_autoxfer_tb_top.sv
module csio_autoxfer_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, start, lsb_first, ext_clk, cs_en, buf_we, sck_i, cs_n;
  logic [4:0] len_m1, buf_addr;
  logic [7:0] buf_wdata, buf_rdata;
  logic       busy, done, aborted, sck_o, sck_oe, so, so_oe, si;
  logic [5:0] done_cnt;
  logic       si_mon, si_ext, ext_drv;

  assign si = ext_drv ? si_ext : si_mon;

  csio_autoxfer dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .len_m1(len_m1),
    .lsb_first(lsb_first), .ext_clk(ext_clk), .cs_en(cs_en),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
    .buf_rdata(buf_rdata), .busy(busy), .done(done), .aborted(aborted),
    .done_cnt(done_cnt), .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
    .si(si), .so(so), .so_oe(so_oe), .cs_n(cs_n)
  );

  int total = 0, fails = 0;
  bit finished = 0;
  logic [7:0] txd [32];
  logic [7:0] slv [32];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  // Behavioural slave model for the internally clocked runs
  bit mon_on = 0, mon_lsb = 0, prev_sck = 1;
  int mon_by = 0, mon_bi = 0, cyc = 0, rise_t = 0, fall_t = 0;
  int done_seen = 0;
  bit prev_done = 0;

  always @(negedge clk) begin
    cyc++;
    if (done) begin
      done_seen++;
      if (prev_done) chk(0, "R9 done width", 2, 1);
    end
    prev_done = done;
    if (mon_on && sck_oe) begin
      if (prev_sck && !sck_o) begin
        if (mon_by > 0 || mon_bi > 0) chk(cyc - rise_t == 8, "R5 high phase", cyc - rise_t, 8);
        fall_t = cyc;
        si_mon = slv[mon_by][mon_lsb ? mon_bi : 7 - mon_bi];
      end
      if (!prev_sck && sck_o) begin
        chk(so == txd[mon_by][mon_lsb ? mon_bi : 7 - mon_bi], "R2 R4 so bit", so,
            txd[mon_by][mon_lsb ? mon_bi : 7 - mon_bi]);
        chk(cyc - fall_t == 8, "R5 low phase", cyc - fall_t, 8);
        if (mon_by > 0 || mon_bi > 0) chk(cyc - rise_t == 16, "R5 period", cyc - rise_t, 16);
        rise_t = cyc;
        mon_bi++;
        if (mon_bi == 8) begin mon_bi = 0; mon_by++; end
      end
      prev_sck = sck_o;
    end else begin
      prev_sck = 1;
    end
  end

  task automatic fill(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      txd[i] = 8'(i * 37 + seed);
      slv[i] = 8'(~(i * 91 + seed * 3));
      @(negedge clk);
      buf_we = 1; buf_addr = 5'(i); buf_wdata = txd[i];
    end
    @(negedge clk);
    buf_we = 0;
  endtask

  task automatic kick(input int n);
    @(negedge clk);
    len_m1 = 5'(n - 1); start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_idle(input int lim);
    for (int i = 0; i < lim && busy; i++) @(negedge clk);
  endtask

  task automatic readback(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      buf_addr = 5'(i);
      #1;
      chk(buf_rdata == slv[i], req, buf_rdata, slv[i]);
    end
  endtask

  task automatic int_run(input int n, input bit lsb, input int seed);
    int d0;
    lsb_first = lsb;
    fill(n, seed);
    mon_by = 0; mon_bi = 0; mon_lsb = lsb; mon_on = 1;
    d0 = done_seen;
    kick(n);
    wait_idle(5000);
    repeat (3) @(negedge clk);
    mon_on = 0;
    chk(mon_by == n && mon_bi == 0, "R1 bytes shifted", mon_by, n);
    chk(done_seen == d0 + 1, "R9 one done", done_seen - d0, 1);
    chk(done_cnt == 6'(n), "R9 done_cnt", done_cnt, n);
    chk(!busy && !aborted, "R9 idle after run", {busy, aborted}, 0);
    readback(n, "R3 received byte stored");
  endtask

  initial begin
    rst_n = 0; start = 0; lsb_first = 0; ext_clk = 0; cs_en = 1; buf_we = 0;
    sck_i = 1; cs_n = 1; len_m1 = 0; buf_addr = 0; buf_wdata = 0;
    si_mon = 0; si_ext = 0; ext_drv = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11
    chk(!busy && !done && !aborted && done_cnt == 0, "R11 status reset", {busy, done, aborted}, 0);
    chk(sck_o == 1, "R11 sck idle", sck_o, 1);
    chk(!so_oe && !sck_oe, "R11 enables off", {so_oe, sck_oe}, 0);

    // Internal clock, no CS gating, MSB first, plus write-while-busy (R10)
    cs_en = 0;
    @(negedge clk);
    buf_we = 1; buf_addr = 5'd20; buf_wdata = 8'hC3;
    @(negedge clk);
    buf_we = 0;
    lsb_first = 0;
    fill(3, 5);
    mon_by = 0; mon_bi = 0; mon_lsb = 0; mon_on = 1;
    kick(3);
    repeat (100) @(negedge clk);
    buf_we = 1; buf_addr = 5'd20; buf_wdata = 8'h5A;
    @(negedge clk);
    buf_we = 0;
    wait_idle(5000);
    repeat (3) @(negedge clk);
    mon_on = 0;
    chk(mon_by == 3, "R1 three bytes", mon_by, 3);
    chk(done_cnt == 6'd3, "R9 done_cnt 3", done_cnt, 3);
    readback(3, "R3 stored msb run");
    @(negedge clk);
    buf_addr = 5'd20;
    #1;
    chk(buf_rdata == 8'hC3, "R10 busy write ignored", buf_rdata, 8'hC3);

    // LSB first, single byte; full 32-byte run
    int_run(1, 1, 77);
    int_run(32, 0, 11);

    // External clock with CS gating (R6, R7)
    cs_en = 1; ext_clk = 1; cs_n = 1; lsb_first = 0;
    fill(2, 200);
    kick(2);
    repeat (20) @(negedge clk);
    chk(busy && done_cnt == 0, "R7 waits for cs", {busy, done_cnt}, 7'h40);
    chk(!so_oe && !sck_oe, "R7 hi-z while cs high", {so_oe, sck_oe}, 0);
    cs_n = 0;
    @(negedge clk);
    chk(!so_oe, "R7 enable delayed", so_oe, 0);
    repeat (3) @(negedge clk);
    chk(so_oe && !sck_oe, "R6 so on sck input", {so_oe, sck_oe}, 2);
    ext_drv = 1;
    for (int b = 0; b < 2; b++) begin
      for (int k = 0; k < 8; k++) begin
        sck_i = 0;
        repeat (10) @(negedge clk);
        chk(so == txd[b][7 - k], "R6 R2 ext so bit", so, txd[b][7 - k]);
        si_ext = slv[b][7 - k];
        sck_i = 1;
        repeat (10) @(negedge clk);
      end
    end
    chk(!busy && done_cnt == 6'd2, "R6 ext run complete", done_cnt, 2);
    readback(2, "R6 R3 ext stored");
    ext_drv = 0;
    cs_n = 1;
    @(negedge clk);
    chk(so_oe, "R7 release delayed", so_oe, 1);
    repeat (3) @(negedge clk);
    chk(!so_oe, "R7 released", so_oe, 0);

    // Abort by CS mid-byte (R8)
    ext_clk = 0; cs_n = 0;
    repeat (4) @(negedge clk);
    fill(3, 9);
    mon_by = 0; mon_bi = 0; mon_lsb = 0; mon_on = 1;
    begin
      int d0;
      d0 = done_seen;
      kick(3);
      for (int i = 0; i < 5000 && !(mon_by == 1 && mon_bi == 3); i++) @(negedge clk);
      mon_on = 0;
      cs_n = 1;
      repeat (5) @(negedge clk);
      chk(!busy && aborted, "R8 aborted", {busy, aborted}, 1);
      chk(done_cnt == 6'd1, "R8 completed count", done_cnt, 1);
      chk(done_seen == d0, "R8 no done", done_seen - d0, 0);
      chk(!so_oe && !sck_oe, "R8 R7 outputs off", {so_oe, sck_oe}, 0);
    end
    readback(1, "R8 first byte kept");

    report();
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    report();
  end
endmodule